// File: doc/BRIEF.md
# Transmit Frame Loader and Trigger

This block moves one outgoing frame from a byte stream into the transmit buffer of an external radio transceiver over SPI, and then starts the transmission. A frame begins with a start pulse that carries the frame length. The block then opens a chip-select window and sends a two-byte long-address write command for buffer address 0. After the command come a header-length byte of zero, the frame-length byte and the frame bytes, which it pulls from the valid/ready input one at a time.

When the burst is over, the block holds chip select high for a short gap. It then writes the transmit-control register with the trigger bit set. The acknowledgement-request bit in that write is copied from the frame's own frame-control field. A one-cycle done pulse closes the frame. A start with length zero is rejected with a one-cycle error pulse. The SPI shifter is part of the block and only writes: it works in mode 0 and sends the most significant bit first.

Top module: `tfl_tx_loader`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, in_ready_o is 0, done_o is 0 and err_o is 0.
- R2: SPI runs in mode 0. sck_o is low whenever cs_no is high. mosi_o is valid on each rising sck_o edge, with the MSB of each byte first. Every chip-select window carries a whole number of bytes.
- R3: The first window of a frame sends 0x80 and then 0x10. This is a long write: bit 15 set, address 0 in bits 14:5 and the write flag in bit 4. The window continues with a header-length byte 0x00, the frame-length byte, and the accepted frame bytes in the order they arrived.
- R4: The transmit buffer holds BUF_BYTES (128) bytes. When len_i is above BUF_BYTES-2 (126), the length byte is 126 and only the first 126 bytes are sent. The block still consumes the remaining len_i-126 bytes from the stream and discards them.
- R5: The second window sends two bytes: 0x37 (short register 0x1B shifted left by one, with bit 0 as the write flag), and then a value. In the value, bit 0 (trigger) is 1 and bit 2 (ack request) equals bit 5 of the first frame byte. All other bits are 0.
- R6: Between the burst window and the trigger window, cs_no stays high for at least 4*SCK_HALF clock cycles, which is two SCK periods.
- R7: Each frame uses exactly two chip-select windows. done_o is a one-cycle pulse after the trigger window closes, and cs_no is high while done_o is high.
- R8: A start_i with len_i equal to 0 produces a one-cycle err_o pulse with cs_no high. It opens no chip-select window and consumes no stream byte.
- R9: A start_i that arrives while a frame is in progress, up to and including its done_o pulse, is ignored. It produces no err_o pulse and does not change the frame being sent.
- R10: Exactly len_i stream bytes are accepted per frame. in_ready_o is high only while the block is waiting for a frame byte or dropping a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame; sampled only while idle |
| len_i | input | LEN_W | Frame length in bytes, taken with start_i |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Stream byte accepted when high with in_valid_i |
| sck_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | SPI data out |
| cs_no | output | 1 | SPI chip select, active low |
| done_o | output | 1 | One-cycle pulse after the trigger write |
| err_o | output | 1 | One-cycle pulse on a rejected zero-length start |

## Verification
The bench sweeps the frame length across 1 to 8, the lengths just below, at and above the 126-byte limit, and a long over-limit frame, with both values of the ack flag. A loader that got truncation wrong would either send a length byte above 126, or stop consuming the stream early and leave the source stalled with bytes still queued. A wrongly copied ack flag shows up as a wrong trigger value. A gap that is too short shows up as a chip-select high time below two SCK periods. A zero-length start offered next to a valid stream byte must raise only err_o. A design that let a start through mid-frame would raise err_o or corrupt the frame in flight.

// File: rtl/tfl_pkg.sv
package tfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_DRAIN, ST_GAP, ST_TRIG, ST_FIN
  } tfl_state_e;

  localparam logic [9:0]  TX_BUF_ADDR  = 10'h000;
  localparam logic [5:0]  TX_CTRL_REG  = 6'h1B;
  localparam int          TRIG_BIT     = 0;
  localparam int          ACKREQ_BIT   = 2;
  localparam int          FC_ACK_BIT   = 5;
  // long write: bit15 long flag, address in 14:5, bit4 write flag
  localparam logic [15:0] LONG_WR_CMD  = 16'h8000 | (16'(TX_BUF_ADDR) << 5) | 16'h0010;
  localparam logic [7:0]  SHORT_WR_CMD = {1'b0, TX_CTRL_REG, 1'b1};
  localparam int          HDR_BYTES    = 4;
  localparam int          TRIG_BYTES   = 2;
endpackage

// File: rtl/tfl_spi_tx.sv
module tfl_spi_tx #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          busy_q, sck_q;
  logic          wrap;

  assign wrap = (div_q == DW'(SCK_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else if (load_i && !busy_q) begin
      sh_q   <= data_i;
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (!wrap) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) busy_q <= 1'b0;
          else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];
endmodule

// File: rtl/tfl_seq.sv
module tfl_seq
  import tfl_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 8,
  parameter int GAP_CYC   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  input  logic             sh_busy_i,
  output logic             sh_load_o,
  output logic [7:0]       sh_data_o,
  output logic             cs_no,
  output logic             done_o,
  output logic             err_o
);
  localparam int MAX_PAY = BUF_BYTES - 2;
  localparam int GW      = $clog2(GAP_CYC + 1);

  tfl_state_e       st_q;
  logic [LEN_W-1:0] pay_q, drop_q, cnt_q, pay_d;
  logic [GW-1:0]    gap_q;
  logic             ack_q, err_q;
  logic             hdr_fire, data_fire, trig_fire, data_want;

  assign pay_d = (len_i > LEN_W'(MAX_PAY)) ? LEN_W'(MAX_PAY) : len_i;

  assign hdr_fire  = (st_q == ST_HDR)  && !sh_busy_i && (cnt_q < LEN_W'(HDR_BYTES));
  assign data_want = (st_q == ST_DATA) && !sh_busy_i && (cnt_q < pay_q);
  assign data_fire = data_want && in_valid_i;
  assign trig_fire = (st_q == ST_TRIG) && !sh_busy_i && (cnt_q < LEN_W'(TRIG_BYTES));

  assign in_ready_o = data_want || ((st_q == ST_DRAIN) && (drop_q != '0));
  assign sh_load_o  = hdr_fire || data_fire || trig_fire;

  always_comb begin
    sh_data_o = in_data_i;
    if (st_q == ST_HDR) begin
      case (cnt_q[1:0])
        2'd0:    sh_data_o = LONG_WR_CMD[15:8];
        2'd1:    sh_data_o = LONG_WR_CMD[7:0];
        2'd2:    sh_data_o = 8'h00;
        default: sh_data_o = 8'(pay_q);
      endcase
    end else if (st_q == ST_TRIG) begin
      if (cnt_q[0] == 1'b0) sh_data_o = SHORT_WR_CMD;
      else begin
        sh_data_o             = 8'h00;
        sh_data_o[TRIG_BIT]   = 1'b1;
        sh_data_o[ACKREQ_BIT] = ack_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pay_q  <= '0;
      drop_q <= '0;
      cnt_q  <= '0;
      gap_q  <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (len_i == '0) err_q <= 1'b1;
          else begin
            pay_q  <= pay_d;
            drop_q <= len_i - pay_d;
            cnt_q  <= '0;
            st_q   <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (hdr_fire) cnt_q <= cnt_q + 1'b1;
          else if (cnt_q == LEN_W'(HDR_BYTES) && !sh_busy_i) begin
            cnt_q <= '0;
            st_q  <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (data_fire) begin
            if (cnt_q == '0) ack_q <= in_data_i[FC_ACK_BIT];
            cnt_q <= cnt_q + 1'b1;
          end else if (cnt_q == pay_q && !sh_busy_i) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (drop_q == '0) begin
            gap_q <= '0;
            st_q  <= ST_GAP;
          end else if (in_valid_i) drop_q <= drop_q - 1'b1;
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_TRIG;
          end else gap_q <= gap_q + 1'b1;
        end
        ST_TRIG: begin
          if (trig_fire) cnt_q <= cnt_q + 1'b1;
          else if (cnt_q == LEN_W'(TRIG_BYTES) && !sh_busy_i) st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = !((st_q == ST_HDR) || (st_q == ST_DATA) || (st_q == ST_TRIG));
  assign done_o = (st_q == ST_FIN);
  assign err_o  = err_q;
endmodule

// File: rtl/tfl_tx_loader.sv
module tfl_tx_loader #(
  parameter int SCK_HALF  = 2,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_no,
  output logic             done_o,
  output logic             err_o
);
  localparam int GAP_CYC = 4 * SCK_HALF;

  logic       sh_busy, sh_load;
  logic [7:0] sh_data;

  tfl_seq #(
    .BUF_BYTES(BUF_BYTES),
    .LEN_W    (LEN_W),
    .GAP_CYC  (GAP_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .len_i     (len_i),
    .in_valid_i(in_valid_i),
    .in_data_i (in_data_i),
    .in_ready_o(in_ready_o),
    .sh_busy_i (sh_busy),
    .sh_load_o (sh_load),
    .sh_data_o (sh_data),
    .cs_no     (cs_no),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  tfl_spi_tx #(
    .SCK_HALF(SCK_HALF)
  ) u_spi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(sh_load),
    .data_i(sh_data),
    .busy_o(sh_busy),
    .sck_o (sck_o),
    .mosi_o(mosi_o)
  );
endmodule

// File: rtl/tfl_tx_loader_chk.sv
module tfl_tx_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sck_o,
  input logic done_o,
  input logic err_o
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) cs_no |-> !sck_o); // R2
  AST_DONE_PULSE:   assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R7
  AST_DONE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> cs_no); // R7
  AST_ERR_PULSE:    assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |=> !err_o); // R8
  AST_ERR_NO_CS:    assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> cs_no); // R8
  AST_ERR_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> !done_o); // R9
endmodule

bind tfl_tx_loader tfl_tx_loader_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cs_no (cs_no),
  .sck_o (sck_o),
  .done_o(done_o),
  .err_o (err_o)
);

// File: tb/sim_tfl_tx_loader.sv
`timescale 1ns/1ps
module sim_tfl_tx_loader;
  localparam int SCK_HALF = 2;
  localparam int MAX_PAY  = 126;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, in_valid_i = 1'b0;
  logic [7:0] len_i = '0, in_data_i = '0;
  logic in_ready_o, sck_o, mosi_o, cs_no, done_o, err_o;

  int n_vec = 0, n_bad = 0;
  logic mon_clr = 1'b0;

  always #2.5 clk = ~clk;

  tfl_tx_loader #(.SCK_HALF(SCK_HALF), .BUF_BYTES(128), .LEN_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .cs_no(cs_no), .done_o(done_o), .err_o(err_o)
  );

  // SPI slave and event monitor, clk-domain sampling
  logic       cs_prev = 1'b1, sck_prev = 1'b0;
  logic [7:0] sr = '0;
  logic [7:0] cap [0:1][0:139];
  int ntr = 0, bitc = 0, part_err = 0, hi_run = 0, gap1 = 0;
  int nb0 = 0, nb1 = 0, err_cnt = 0, done_cnt = 0, hs = 0;

  always @(posedge clk) begin
    if (mon_clr) begin
      ntr = 0; bitc = 0; part_err = 0; gap1 = 0; nb0 = 0; nb1 = 0;
      err_cnt = 0; done_cnt = 0; hs = 0;
    end else begin
      if (!cs_no && cs_prev) begin
        if (ntr == 1) gap1 = hi_run;
        bitc = 0;
      end
      if (cs_no) hi_run++; else hi_run = 0;
      if (!cs_no && sck_o && !sck_prev) begin
        sr = {sr[6:0], mosi_o};
        bitc++;
        if (bitc == 8) begin
          bitc = 0;
          if (ntr == 0) begin if (nb0 < 140) cap[0][nb0] = sr; nb0++; end
          else if (ntr == 1) begin if (nb1 < 140) cap[1][nb1] = sr; nb1++; end
        end
      end
      if (cs_no && !cs_prev) begin
        if (bitc != 0) part_err++;
        ntr++;
      end
      if (err_o) err_cnt++;
      if (done_o) done_cnt++;
      if (in_valid_i && in_ready_o) hs++;
    end
    cs_prev  = cs_no;
    sck_prev = sck_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    logic [7:0] b;
    b = 8'((seed * 11 + k * 37 + (k >> 3)) & 255);
    if (k == 0) b[5] = seed[0];
    return b;
  endfunction

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic send_stream(input int n, input int seed);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      in_data_i  = pat(seed, k);
      if (in_ready_o) k++;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic run_frame(input int L, input int seed, input bit mid);
    int pay, w;
    logic [7:0] exp_trig;
    pay = (L > MAX_PAY) ? MAX_PAY : L;
    clear_mon();
    fork
      begin
        @(negedge clk); start_i = 1'b1; len_i = 8'(L);
        @(negedge clk); start_i = 1'b0;
        if (mid) begin
          repeat (150) @(negedge clk);
          start_i = 1'b1; len_i = 8'd0;   // R9 zero-length start mid-frame
          @(negedge clk); len_i = 8'd3;
          @(negedge clk); start_i = 1'b0;
        end
      end
      send_stream(L, seed);
    join
    w = 0;
    while (done_cnt == 0 && w < 20000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R7 done pulses", done_cnt, 1);
    chk(ntr == 2, "R7 cs windows", ntr, 2);
    chk(part_err == 0, "R2 partial byte", part_err, 0);
    chk(hs == L, "R10 bytes consumed", hs, L);
    chk(err_cnt == 0, "R9 spurious err", err_cnt, 0);
    chk(nb0 == 4 + pay, "R4 burst byte count", nb0, 4 + pay);
    chk(cap[0][0] == 8'h80, "R3 cmd hi", cap[0][0], 8'h80);
    chk(cap[0][1] == 8'h10, "R3 cmd lo", cap[0][1], 8'h10);
    chk(cap[0][2] == 8'h00, "R3 hdr len", cap[0][2], 0);
    chk(cap[0][3] == 8'(pay), "R4 frame len byte", cap[0][3], pay);
    for (int k = 0; k < pay && k < 136; k++)
      chk(cap[0][4+k] == pat(seed, k), "R3 payload", cap[0][4+k], pat(seed, k));
    exp_trig = 8'h01 | (seed[0] ? 8'h04 : 8'h00);
    chk(nb1 == 2, "R5 trig byte count", nb1, 2);
    chk(cap[1][0] == 8'h37, "R5 trig cmd", cap[1][0], 8'h37);
    chk(cap[1][1] == exp_trig, "R5 trig value", cap[1][1], exp_trig);
    chk(gap1 >= 4 * SCK_HALF, "R6 cs gap", gap1, 4 * SCK_HALF);
    chk(cs_no == 1'b1 && sck_o == 1'b0, "R2 idle lines", {cs_no, sck_o}, 2);
  endtask

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_bad++; n_vec++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int c = 0; c < 140; c++) begin cap[0][c] = '0; cap[1][c] = '0; end
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1, "R1 cs_no", cs_no, 1);
    chk(sck_o == 1'b0, "R1 sck_o", sck_o, 0);
    chk(in_ready_o == 1'b0, "R1 in_ready_o", in_ready_o, 0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R1 done/err", {done_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R8: zero length with a byte on offer
    clear_mon();
    @(negedge clk); in_valid_i = 1'b1; in_data_i = 8'h5A; start_i = 1'b1; len_i = 8'd0;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    in_valid_i = 1'b0;
    chk(err_cnt == 1, "R8 err pulse", err_cnt, 1);
    chk(ntr == 0 && !cs_no == 1'b0, "R8 no cs window", ntr, 0);
    chk(hs == 0, "R8 no byte consumed", hs, 0);
    chk(done_cnt == 0, "R8 no done", done_cnt, 0);

    for (int L = 1; L <= 8; L++) run_frame(L, L, 1'b0);
    run_frame(60, 6, 1'b1);
    run_frame(125, 3, 1'b0);
    run_frame(126, 4, 1'b1);
    run_frame(127, 9, 1'b0);
    run_frame(128, 10, 1'b0);
    run_frame(200, 13, 1'b1);
    run_frame(255, 2, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule